// File: doc/BRIEF.md
# Scaled-Index Shift-and-Add Unit

This block forms scaled-index addresses and similar sums in one pipeline stage. Operand B is shifted left by a small immediate plus one, with the bits pushed off the top dropped and zeros filled in at the bottom. Operand A is then added, and the sum wraps modulo 2^XLEN. Before the shift, a two-bit mode can reshape B: B can be used at full width, or only its lower half can be used, either sign-extended or zero-extended to XLEN bits.

Each accepted operation gives a registered result one clock after the request. When the request asks for condition recording, a three-bit signed comparison of the result against zero is registered as well. No carry or overflow information is produced.

Top module: `sadd_unit`

## Requirements
- R1: The shift distance is `in_sh + 1`. With the default 2-bit `in_sh`, code 0 shifts by one place and code 3 shifts by four places.
- R2: In full mode (`in_mode` = 2'b00) the result is `(in_b << (in_sh+1)) + in_a`. Bits of B shifted beyond bit XLEN-1 are lost.
- R3: In signed-half mode (`in_mode` = 2'b01), B is replaced by its lower XLEN/2 bits before the shift. The upper half is filled with copies of bit XLEN/2-1, where bit 0 is the least significant bit.
- R4: In unsigned-half mode (`in_mode` = 2'b10), B is replaced by its lower XLEN/2 bits, with zeros in the upper half, before the shift.
- R5: Mode code 2'b11 gives the same result as full mode.
- R6: An operation presented with `in_valid` high appears on `out_result` with `out_valid` high exactly one clock later. In a cycle after one with `in_valid` low, `out_valid` is low and `out_result` keeps its previous value.
- R7: The addition wraps modulo 2^XLEN. A carry out of bit XLEN-1 is discarded.
- R8: When an accepted operation has `in_rc` high, `out_cr_we` is high alongside `out_valid`. `out_cr` then holds the signed comparison of the result with zero: bit 2 set means negative, bit 1 set means positive, bit 0 set means zero. Exactly one of these bits is set.
- R9: When an accepted operation has `in_rc` low, `out_cr_we` is low and `out_cr` keeps its previous value.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_cr_we`, `out_result` and `out_cr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request |
| in_mode | input | 2 | Operand B shaping mode |
| in_sh | input | SH_W | Immediate shift code; distance is code plus one |
| in_rc | input | 1 | Record condition bits for this operation |
| in_a | input | XLEN | Addend |
| in_b | input | XLEN | Operand to be shaped and shifted |
| out_valid | output | 1 | Result valid |
| out_result | output | XLEN | Registered sum |
| out_cr_we | output | 1 | Condition bits updated this cycle |
| out_cr | output | 3 | {negative, positive, zero} of the last recorded result |

## Verification
The bench uses shift code 0 to catch an unshifted or off-by-one distance, and code 3 with high bits set in B to check that overflowed bits are dropped rather than kept. It feeds half-width operands with and without bit XLEN/2-1 set. A design with swapped extension modes, or with the sign taken from the wrong bit, gives a wrong upper half there. Sums that wrap past 2^XLEN, and a sum of exactly zero, show a leaked carry or wrong condition bits. A request without recording follows a recorded one, which exposes a condition register that is cleared when it should have been held.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    // Operand B shaping modes
    typedef enum logic [1:0] {
        SA_FULL  = 2'b00,
        SA_SWORD = 2'b01,
        SA_UWORD = 2'b10,
        SA_ALT   = 2'b11
    } sa_mode_e;

    // Signed comparison of a result against zero
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
    } sa_cond_t;

    localparam int COND_W = $bits(sa_cond_t);

    // The spare code is folded onto full width
    function automatic sa_mode_e sa_norm_mode(input logic [1:0] code);
        sa_mode_e m;
        m = sa_mode_e'(code);
        if (m == SA_ALT) begin
            m = SA_FULL;
        end
        return m;
    endfunction

endpackage

// File: rtl/sadd_extend.sv
module sadd_extend
    import sadd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  sa_mode_e          mode,
    input  logic [XLEN-1:0]   opnd,
    output logic [XLEN-1:0]   shaped
);
    localparam int HALF = XLEN / 2;

    logic [HALF-1:0] low_half;
    logic            low_msb;

    assign low_half = opnd[HALF-1:0];
    assign low_msb  = opnd[HALF-1];

    always_comb begin
        unique case (mode)
            SA_SWORD: shaped = {{(XLEN-HALF){low_msb}}, low_half};
            SA_UWORD: shaped = {{(XLEN-HALF){1'b0}}, low_half};
            default:  shaped = opnd;
        endcase
    end
endmodule

// File: rtl/sadd_shifter.sv
module sadd_shifter #(
    parameter int XLEN = 64,
    parameter int SH_W = 2
) (
    input  logic [XLEN-1:0] din,
    input  logic [SH_W-1:0] code,
    output logic [XLEN-1:0] dout
);
    localparam int NAMT = 1 << SH_W;

    logic [XLEN-1:0] cand [NAMT];

    // One fixed-distance candidate per code; distance is code plus one
    for (genvar k = 0; k < NAMT; k++) begin : g_amt
        assign cand[k] = din << (k + 1);
    end

    assign dout = cand[code];
endmodule

// File: rtl/sadd_cond.sv
module sadd_cond
    import sadd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] value,
    output sa_cond_t        cond
);
    always_comb begin
        cond.zero = ~|value;
        cond.neg  = value[XLEN-1];
        cond.pos  = ~value[XLEN-1] & ~cond.zero;
    end
endmodule

// File: rtl/sadd_unit.sv
module sadd_unit
    import sadd_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SH_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_mode,
    input  logic [SH_W-1:0]   in_sh,
    input  logic              in_rc,
    input  logic [XLEN-1:0]   in_a,
    input  logic [XLEN-1:0]   in_b,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_result,
    output logic              out_cr_we,
    output logic [2:0]        out_cr
);
    sa_mode_e        mode;
    logic [XLEN-1:0] b_shaped;
    logic [XLEN-1:0] b_scaled;
    logic [XLEN-1:0] sum;
    sa_cond_t        cond;

    assign mode = sa_norm_mode(in_mode);

    sadd_extend #(.XLEN(XLEN)) u_ext (
        .mode   (mode),
        .opnd   (in_b),
        .shaped (b_shaped)
    );

    sadd_shifter #(.XLEN(XLEN), .SH_W(SH_W)) u_shf (
        .din  (b_shaped),
        .code (in_sh),
        .dout (b_scaled)
    );

    // Modular add: carry out is dropped by the width of sum
    assign sum = b_scaled + in_a;

    sadd_cond #(.XLEN(XLEN)) u_cond (
        .value (sum),
        .cond  (cond)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_cr_we  <= 1'b0;
            out_result <= '0;
            out_cr     <= '0;
        end else begin
            out_valid <= in_valid;
            out_cr_we <= in_valid & in_rc;
            if (in_valid) begin
                out_result <= sum;
            end
            if (in_valid && in_rc) begin
                out_cr <= cond;
            end
        end
    end
endmodule

// File: rtl/sadd_unit_chk.sv
module sadd_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_rc,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic            out_cr_we,
    input logic [2:0]      out_cr
);
    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    // R8
    cr_we_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_rc) |=> out_cr_we);

    // R8
    cr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        out_cr_we |-> ($countones(out_cr) == 1));

    // R8
    cr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_cr_we |-> (out_cr[0] == (out_result == '0)));

    // R9
    cr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_rc) |=> (!out_cr_we && $stable(out_cr)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_cr_we && out_result == '0 && out_cr == '0));
endmodule

bind sadd_unit sadd_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sadd_unit_bench.sv
`timescale 1ns/1ps
module sadd_unit_bench;
    localparam int XW = 64;

    typedef struct packed {
        logic [1:0]    mode;
        logic [1:0]    sh;
        logic          rc;
        logic [XW-1:0] a;
        logic [XW-1:0] b;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{2'b00, 2'd0, 1'b1, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_0010},
        '{2'b00, 2'd3, 1'b1, 64'h0000_0000_0000_0005, 64'hF000_0000_0000_0001},
        '{2'b00, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
        '{2'b00, 2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0000_0000_0000_0001},
        '{2'b01, 2'd1, 1'b1, 64'h0000_0000_0000_0000, 64'h1234_5678_8000_0003},
        '{2'b01, 2'd2, 1'b1, 64'h0000_0000_0000_0100, 64'hFFFF_FFFF_7FFF_FFFF},
        '{2'b10, 2'd1, 1'b1, 64'h0000_0000_0000_0000, 64'h1234_5678_8000_0003},
        '{2'b10, 2'd3, 1'b0, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'b11, 2'd1, 1'b1, 64'h0000_0000_0000_0007, 64'hC000_0000_8000_0001},
        '{2'b01, 2'd0, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_mode = '0;
    logic [1:0]    in_sh = '0;
    logic          in_rc = 1'b0;
    logic [XW-1:0] in_a = '0;
    logic [XW-1:0] in_b = '0;
    logic          out_valid;
    logic [XW-1:0] out_result;
    logic          out_cr_we;
    logic [2:0]    out_cr;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0]    last_cr = '0;
    logic [XW-1:0] last_res = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sadd_unit u_sadd_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_sh(in_sh), .in_rc(in_rc), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result),
        .out_cr_we(out_cr_we), .out_cr(out_cr)
    );

    function automatic logic [XW-1:0] ref_sum(input logic [1:0] m, input logic [1:0] s,
                                             input logic [XW-1:0] a, input logic [XW-1:0] b);
        logic [XW-1:0] bx;
        logic [XW-1:0] r;
        case (m)
            2'b01:   bx = {{32{b[31]}}, b[31:0]};
            2'b10:   bx = {32'h0, b[31:0]};
            default: bx = b;
        endcase
        r = (bx << (s + 1)) + a;
        return r;
    endfunction

    function automatic logic [2:0] ref_cr(input logic [XW-1:0] r);
        return {$signed(r) < 0, $signed(r) > 0, r == '0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [XW-1:0] act,
                         input logic [XW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Drive one op, then sample one cycle later at the falling edge
    task automatic apply(input vec_t v, input string tag);
        logic [XW-1:0] er;
        @(negedge clk);
        in_valid = 1'b1; in_mode = v.mode; in_sh = v.sh; in_rc = v.rc;
        in_a = v.a; in_b = v.b;
        @(negedge clk);
        in_valid = 1'b0;
        er = ref_sum(v.mode, v.sh, v.a, v.b);
        if (v.rc) last_cr = ref_cr(er);
        last_res = er;
        check(out_valid == 1'b1, {tag, " R6 valid"}, XW'(out_valid), XW'(1));
        check(out_result == er, tag, out_result, er);
        check(out_cr_we == v.rc, {tag, " R8/R9 cr_we"}, XW'(out_cr_we), XW'(v.rc));
        check(out_cr == last_cr, {tag, " R8/R9 cr"}, XW'(out_cr), XW'(last_cr));
    endtask

    initial begin
        #(5.0 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check(out_valid == 0 && out_cr_we == 0, "R10 flags", XW'({out_valid, out_cr_we}), '0);
        check(out_result == '0, "R10 result", out_result, '0);
        check(out_cr == '0, "R10 cr", XW'(out_cr), '0);

        // Table walk: R1, R2, R3, R4, R5, R7 by vector
        for (int i = 0; i < NV; i++) begin
            apply(VT[i], $sformatf("vec%0d R1/R2/R3/R4/R5/R7", i));
        end

        // R1 direct: shift code 0 moves by one place, code 3 by four
        apply('{2'b00, 2'd0, 1'b1, 64'h0, 64'h1}, "R1 sh0");
        check(out_result == 64'h2, "R1 sh0 dist", out_result, 64'h2);
        apply('{2'b00, 2'd3, 1'b1, 64'h0, 64'h1}, "R1 sh3");
        check(out_result == 64'h10, "R1 sh3 dist", out_result, 64'h10);

        // R7: wrap to zero, zero flag set
        apply('{2'b00, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1}, "R7 wrap");
        check(out_cr == 3'b001, "R7 zero cr", XW'(out_cr), XW'(3'b001));

        // R9: recorded negative, then unrecorded op must keep cr
        apply('{2'b00, 2'd0, 1'b1, 64'h8000_0000_0000_0000, 64'h0}, "R8 neg");
        check(out_cr == 3'b100, "R8 neg cr", XW'(out_cr), XW'(3'b100));
        apply('{2'b00, 2'd0, 1'b0, 64'h1, 64'h0}, "R9 norec");
        check(out_cr == 3'b100, "R9 cr held", XW'(out_cr), XW'(3'b100));

        // R6: idle cycles keep result, valid low
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R6 idle valid", XW'(out_valid), '0);
        check(out_result == last_res, "R6 idle result", out_result, last_res);
        check(out_cr_we == 1'b0, "R9 idle cr_we", XW'(out_cr_we), '0);

        // R10: reset after activity clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_result == '0 && out_cr == '0 && !out_valid, "R10 re-reset",
              out_result, '0);

        finish_run();
    end
endmodule